// File: doc/BRIEF.md
# Spatial Dither Bit-Depth Reducer

This block narrows a stream of 12-bit-per-channel RGB pixels to 6 or 8 bits per channel for a display link that carries fewer bits than the pixel pipeline. Before the low bits are dropped, each channel adds pseudo-random noise to the bits that will be discarded. This spreads the quantisation error spatially, so smooth gradients do not show bands. The noise comes from one 28-bit linear feedback shift register per channel. The register can use a single shared polynomial or a different polynomial per channel. It can be reloaded from its seed at each frame start, and it can be shaped by a simple high-pass difference.

Pixels enter on a valid/ready stream that carries a start-of-frame flag, and leave on a valid/ready stream. A pixel is taken when `in_valid` and `in_ready` are both high at a rising edge. An output pixel is handed over when `out_valid` and `out_ready` are both high. The pipeline stalls as a whole whenever a result is waiting and `out_ready` is low. It therefore drives `in_ready` as `!out_valid || out_ready`, and it holds the output steady while it is refused.

Configuration inputs are treated as static. They change only while the pipeline is empty.

Top module: `pix_dither_reducer`

## Requirements
- R1: `cfg_depth` = 0 selects 6-bit output. The 6-bit result is left-aligned in the 8-bit output port, and its two low bits are zero. `cfg_depth` = 1 selects the full 8-bit output.
- R2: `cfg_depth` codes 2 and 3 (a 10-bit target, not supported) never add noise, even with `cfg_dither_en` high. The output is the plain 8-bit truncation.
- R3: With `cfg_dither_en` low, each output channel is the input channel truncated to the selected depth. For 8-bit this is bits [11:4]. For 6-bit it is bits [11:6] followed by two zeros.
- R4: Each generator shifts left by one bit per accepted pixel while dithering is active. The new LSB is state[27] XOR state[k-1] for the polynomial x^28 + x^k + 1. The noise is the state's low D bits, with D = 6 for 6-bit output and D = 4 for 8-bit output. With `cfg_per_chan` low, all three channels use k = 3.
- R5: With `cfg_per_chan` high, the red channel uses k = 3, green uses k = 9 and blue uses k = 13.
- R6: After reset, or after any cycle in which dithering is inactive, the next accepted pixel takes its noise from the channel's seed (`cfg_seed_*`). Later pixels use the advanced state.
- R7: With `cfg_frame_rand` high, a pixel accepted with `in_sof` high takes its noise from the seed again. With `cfg_frame_rand` low, `in_sof` has no effect.
- R8: With `cfg_highpass` high, the noise is (cur − prev + 2^D) / 2, rounded down. Here cur is the current low D bits and prev is the low D bits used by the previous pixel of the same channel. prev is 0 whenever the seed is loaded.
- R9: The input plus noise saturates at 4095 before truncation, so a full-scale input stays at full scale.
- R10: After reset `out_valid` is 0 and `in_ready` is 1. With `out_ready` high, a pixel accepted at one rising edge is presented with `out_valid` high after the next rising edge. This gives a 2-cycle latency from the input cycle.
- R11: While `out_valid` is high and `out_ready` is low, the output pixel and `out_valid` hold and `in_ready` is low. No pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |
| cfg_dither_en | input | 1 | Enable noise injection |
| cfg_depth | input | 2 | 0: 6-bit, 1: 8-bit, 2/3: unsupported (no noise, 8-bit) |
| cfg_per_chan | input | 1 | Per-channel polynomials |
| cfg_frame_rand | input | 1 | Reseed at every start of frame |
| cfg_highpass | input | 1 | High-pass shaped noise |
| cfg_seed_r | input | 28 | Red generator seed |
| cfg_seed_g | input | 28 | Green generator seed |
| cfg_seed_b | input | 28 | Blue generator seed |

## Verification
The frame-start reseed and the high-pass history can act on the same pixel. A start-of-frame pixel must then use its seed and also treat the previous sample as zero. The bench provokes this by streaming several frames with both options on. A behavioural model predicts each output and is compared on every handshake. The start-of-frame reload can also coincide with an output stall. A phase with pseudo-random `out_ready` sends framed data and checks both that the held output stays stable and that the reseed is applied to exactly one accepted pixel.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  typedef enum logic [1:0] {
    DEPTH_6   = 2'd0,
    DEPTH_8   = 2'd1,
    DEPTH_10  = 2'd2,
    DEPTH_RSV = 2'd3
  } depth_e;

  localparam int GEN_W = 28;

  // One Fibonacci step for x^GEN_W + x^tap + 1, shifting toward the MSB.
  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s,
                                                input int unsigned tap);
    logic fb;
    fb = s[GEN_W-1] ^ s[tap-1];
    return {s[GEN_W-2:0], fb};
  endfunction

endpackage

// File: rtl/pdr_noise_gen.sv
module pdr_noise_gen
  import pdr_pkg::*;
#(
  parameter int NOISE_W    = 6,
  parameter int DROP_WIDE  = 4,
  parameter int TAP_OWN    = 3,
  parameter int TAP_SHARED = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               narrow,
  input  logic               per_chan,
  input  logic               frame_rand,
  input  logic               highpass,
  input  logic               sof,
  input  logic               accept,
  input  logic [GEN_W-1:0]   seed,
  output logic [NOISE_W-1:0] noise
);

  localparam logic [NOISE_W-1:0] MASK_NARROW = '1;
  localparam logic [NOISE_W-1:0] MASK_WIDE   = NOISE_W'((1 << DROP_WIDE) - 1);
  localparam logic [NOISE_W:0]   HALF_NARROW = (NOISE_W+1)'(1 << NOISE_W);
  localparam logic [NOISE_W:0]   HALF_WIDE   = (NOISE_W+1)'(1 << DROP_WIDE);

  logic [GEN_W-1:0]   state_q;
  logic [NOISE_W-1:0] prev_q;
  logic               armed_q;

  logic               reload;
  logic [GEN_W-1:0]   eff;
  logic [NOISE_W-1:0] eff_prev;
  logic [NOISE_W-1:0] mask;
  logic [NOISE_W-1:0] raw;
  logic [NOISE_W-1:0] last;
  logic [NOISE_W:0]   diff;
  logic [NOISE_W-1:0] shaped;
  int unsigned        tap;

  always_comb begin
    reload   = !armed_q || (sof && frame_rand);
    eff      = reload ? seed : state_q;
    eff_prev = reload ? '0 : prev_q;
    mask     = narrow ? MASK_NARROW : MASK_WIDE;
    raw      = eff[NOISE_W-1:0] & mask;
    last     = eff_prev & mask;
    diff     = {1'b0, raw} - {1'b0, last} + (narrow ? HALF_NARROW : HALF_WIDE);
    shaped   = diff[NOISE_W:1];
    tap      = per_chan ? TAP_OWN : TAP_SHARED;
    if (!active)       noise = '0;
    else if (highpass) noise = shaped;
    else               noise = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else if (!active) begin
      armed_q <= 1'b0;
    end else if (accept) begin
      state_q <= gen_step(eff, tap);
      prev_q  <= eff[NOISE_W-1:0];
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pdr_chan_reduce.sv
module pdr_chan_reduce #(
  parameter int PIX_W    = 12,
  parameter int OUT_W    = 8,
  parameter int NARROW_W = 6,
  parameter int NOISE_W  = 6
) (
  input  logic [PIX_W-1:0]   pix,
  input  logic [NOISE_W-1:0] noise,
  input  logic               narrow,
  output logic [OUT_W-1:0]   reduced
);

  localparam int PAD_W = OUT_W - NARROW_W;

  logic [PIX_W:0]   sum;
  logic [PIX_W-1:0] sat;

  always_comb begin
    sum = {1'b0, pix} + {{(PIX_W+1-NOISE_W){1'b0}}, noise};
    sat = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    if (narrow) reduced = {sat[PIX_W-1 -: NARROW_W], {PAD_W{1'b0}}};
    else        reduced = sat[PIX_W-1 -: OUT_W];
  end

endmodule

// File: rtl/pix_dither_reducer.sv
module pix_dither_reducer
  import pdr_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int OUT_W      = 8,
  parameter int NARROW_W   = 6,
  parameter int TAP_SHARED = 3,
  parameter int TAP_R      = 3,
  parameter int TAP_G      = 9,
  parameter int TAP_B      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b,
  input  logic             cfg_dither_en,
  input  logic [1:0]       cfg_depth,
  input  logic             cfg_per_chan,
  input  logic             cfg_frame_rand,
  input  logic             cfg_highpass,
  input  logic [GEN_W-1:0] cfg_seed_r,
  input  logic [GEN_W-1:0] cfg_seed_g,
  input  logic [GEN_W-1:0] cfg_seed_b
);

  localparam int DROP_WIDE   = PIX_W - OUT_W;
  localparam int DROP_NARROW = PIX_W - NARROW_W;
  localparam int NOISE_W     = DROP_NARROW;
  localparam int NCH         = 3;

  logic advance;
  logic accept;
  logic dith_active;
  logic narrow;

  logic [PIX_W-1:0]   pix_in   [NCH];
  logic [GEN_W-1:0]   seed_in  [NCH];
  logic [NOISE_W-1:0] noise    [NCH];
  logic [PIX_W-1:0]   s1_pix   [NCH];
  logic [NOISE_W-1:0] s1_noise [NCH];
  logic [OUT_W-1:0]   reduced  [NCH];
  logic [OUT_W-1:0]   out_q    [NCH];

  logic s1_valid;
  logic s1_narrow;
  logic out_valid_q;

  assign advance     = !out_valid_q || out_ready;
  assign accept      = in_valid && advance;
  assign in_ready    = advance;
  assign dith_active = cfg_dither_en &&
                       (cfg_depth == DEPTH_6 || cfg_depth == DEPTH_8);
  assign narrow      = (cfg_depth == DEPTH_6);

  assign pix_in[0]  = in_r;
  assign pix_in[1]  = in_g;
  assign pix_in[2]  = in_b;
  assign seed_in[0] = cfg_seed_r;
  assign seed_in[1] = cfg_seed_g;
  assign seed_in[2] = cfg_seed_b;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int TAP_OWN = (c == 0) ? TAP_R : (c == 1) ? TAP_G : TAP_B;

    pdr_noise_gen #(
      .NOISE_W   (NOISE_W),
      .DROP_WIDE (DROP_WIDE),
      .TAP_OWN   (TAP_OWN),
      .TAP_SHARED(TAP_SHARED)
    ) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (dith_active),
      .narrow    (narrow),
      .per_chan  (cfg_per_chan),
      .frame_rand(cfg_frame_rand),
      .highpass  (cfg_highpass),
      .sof       (in_sof),
      .accept    (accept),
      .seed      (seed_in[c]),
      .noise     (noise[c])
    );

    pdr_chan_reduce #(
      .PIX_W   (PIX_W),
      .OUT_W   (OUT_W),
      .NARROW_W(NARROW_W),
      .NOISE_W (NOISE_W)
    ) u_red (
      .pix    (s1_pix[c]),
      .noise  (s1_noise[c]),
      .narrow (s1_narrow),
      .reduced(reduced[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_pix[c]   <= '0;
        s1_noise[c] <= '0;
        out_q[c]    <= '0;
      end else if (advance) begin
        s1_pix[c]   <= pix_in[c];
        s1_noise[c] <= noise[c];
        out_q[c]    <= reduced[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_narrow   <= 1'b0;
      out_valid_q <= 1'b0;
    end else if (advance) begin
      s1_valid    <= in_valid;
      s1_narrow   <= narrow;
      out_valid_q <= s1_valid;
    end
  end

  assign out_valid = out_valid_q;
  assign out_r     = out_q[0];
  assign out_g     = out_q[1];
  assign out_b     = out_q[2];

endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
  parameter int PIX_W = 12,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_r,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_r,
  input logic [OUT_W-1:0] out_g,
  input logic [OUT_W-1:0] out_b,
  input logic             cfg_dither_en,
  input logic [1:0]       cfg_depth
);

  // R10: a new output is always preceded by an accepted input two samples back
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  // R11: a refused output holds
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r) &&
                                   $stable(out_g) && $stable(out_b)));

  // R1: 6-bit results carry zero padding below
  assert_lowzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_depth == 2'd0) |->
      (out_r[1:0] == 2'b00 && out_g[1:0] == 2'b00 && out_b[1:0] == 2'b00));

  // R3: no noise means plain truncation of the pixel taken two samples back
  assert_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_dither_en && cfg_depth == 2'd1 &&
     $past(in_valid && in_ready, 2) && $past(out_ready, 1)) |->
      (out_r == $past(in_r[PIX_W-1 -: OUT_W], 2)));

endmodule

bind pix_dither_reducer pdr_checker #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_r         (in_r),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_r        (out_r),
  .out_g        (out_g),
  .out_b        (out_b),
  .cfg_dither_en(cfg_dither_en),
  .cfg_depth    (cfg_depth)
);

// File: tb/pix_dither_reducer_tb.sv
module pix_dither_reducer_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic        in_ready;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_r, out_g, out_b;
  logic        cfg_dither_en = 1'b0, cfg_per_chan = 1'b0;
  logic        cfg_frame_rand = 1'b0, cfg_highpass = 1'b0;
  logic [1:0]  cfg_depth = 2'd1;
  logic [27:0] cfg_seed_r = 28'h5A3C0F1, cfg_seed_g = 28'h0D1E2F3;
  logic [27:0] cfg_seed_b = 28'hB00B135;

  pix_dither_reducer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .cfg_dither_en(cfg_dither_en), .cfg_depth(cfg_depth),
    .cfg_per_chan(cfg_per_chan), .cfg_frame_rand(cfg_frame_rand),
    .cfg_highpass(cfg_highpass), .cfg_seed_r(cfg_seed_r),
    .cfg_seed_g(cfg_seed_g), .cfg_seed_b(cfg_seed_b)
  );

  int    checks = 0, errors = 0;
  string req = "R10";
  bit    bp_mode = 1'b0;
  bit    finished = 1'b0;

  // behavioural model state
  bit [27:0] m_gen [3];
  int        m_last [3];
  bit        m_armed = 1'b0;
  int        exp_q [$];
  bit        was_refused = 1'b0;
  int        held_val = 0;

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", r, act, exp);
    end
  endtask

  function automatic bit [27:0] next_gen(bit [27:0] s, int k);
    int fb;
    fb = ((s >> 27) & 1) ^ ((s >> (k - 1)) & 1);
    return ((s << 1) | 28'(fb)) & 28'hFFFFFFF;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      // output side
      if (was_refused) check({req, "/R11 hold"}, out_valid ? {out_r, out_g, out_b} : -1, held_val);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check({req, " unexpected"}, {out_r, out_g, out_b}, -1);
        else check(req, {out_r, out_g, out_b}, exp_q.pop_front());
      end
      was_refused = out_valid && !out_ready;
      held_val    = {out_r, out_g, out_b};
      // input side
      begin
        bit active, narrow, reload;
        int d, pix, n, raw, pv, s, o, e, k;
        bit [27:0] eff;
        int seeds [3];
        int pixs [3];
        seeds[0] = int'(cfg_seed_r); seeds[1] = int'(cfg_seed_g); seeds[2] = int'(cfg_seed_b);
        pixs[0] = int'(in_r); pixs[1] = int'(in_g); pixs[2] = int'(in_b);
        active = cfg_dither_en && cfg_depth < 2;
        narrow = (cfg_depth == 0);
        d = narrow ? 6 : 4;
        if (in_valid && in_ready) begin
          e = 0;
          reload = !m_armed || (in_sof && cfg_frame_rand);
          for (int c = 0; c < 3; c++) begin
            eff = reload ? 28'(seeds[c]) : m_gen[c];
            raw = int'(eff) % (1 << d);
            pv  = reload ? 0 : m_last[c] % (1 << d);
            n   = cfg_highpass ? (raw - pv + (1 << d)) / 2 : raw;
            if (!active) n = 0;
            s = pixs[c] + n;
            if (s > 4095) s = 4095;
            o = narrow ? (s / 64) * 4 : s / 16;
            e = e * 256 + o;
            k = !cfg_per_chan ? 3 : (c == 0 ? 3 : (c == 1 ? 9 : 13));
            if (active) begin
              m_gen[c]  = next_gen(eff, k);
              m_last[c] = int'(eff) % 64;
            end
          end
          exp_q.push_back(e);
          if (active) m_armed = 1'b1;
        end
        if (!active) m_armed = 1'b0;
      end
    end
  end

  // output back-pressure driver
  initial begin
    bit [7:0] p = 8'hA7;
    forever begin
      @(posedge clk); #2;
      p = {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
      out_ready = bp_mode ? (p[0] | p[2]) : 1'b1;
    end
  end

  task automatic send(int r, int g, int b, bit sof);
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b); in_sof = sof; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #2;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic stream(int n, int salt, int frame_len);
    for (int i = 0; i < n; i++)
      send((i * 397 + salt) % 4096, (i * 811 + salt * 3 + 5) % 4096,
           (i * 1237 + salt * 7 + 9) % 4096, (i % frame_len) == 0);
  endtask

  task automatic setup(bit en, int depth, bit pc, bit fr, bit hp);
    cfg_dither_en = en; cfg_depth = 2'(depth); cfg_per_chan = pc;
    cfg_frame_rand = fr; cfg_highpass = hp;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    req = "R10";
    check("R10 reset out_valid", int'(out_valid), 0);
    check("R10 reset in_ready", int'(in_ready), 1);
    @(posedge clk); #2;

    req = "R3";  setup(0, 1, 0, 0, 0); stream(12, 3, 100);   drain();
    req = "R1";  setup(0, 0, 0, 0, 0); stream(12, 17, 100);  drain();
    req = "R2";  setup(1, 2, 1, 1, 1); stream(10, 29, 4);    drain();
    req = "R2";  setup(1, 3, 0, 0, 0); stream(6, 31, 100);   drain();
    req = "R4";  setup(1, 1, 0, 0, 0); stream(30, 41, 100);  drain();
    req = "R1";  setup(1, 0, 0, 0, 0); stream(20, 43, 100);  drain();
    req = "R5";  setup(1, 1, 1, 0, 0); stream(30, 53, 100);  drain();
    req = "R6";  setup(0, 1, 1, 0, 0); setup(1, 1, 1, 0, 0);
    stream(8, 53, 100); drain();
    req = "R7";  setup(1, 1, 1, 1, 0); stream(8, 61, 100); stream(8, 61, 100); drain();
    req = "R7";  setup(1, 0, 0, 0, 0); stream(24, 67, 8);   drain();
    req = "R8";  setup(1, 0, 1, 1, 1); stream(30, 71, 10);  drain();
    req = "R8";  setup(1, 1, 0, 0, 1); stream(20, 73, 100); drain();
    req = "R9";  setup(1, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) send(4095, 4095 - i, 4088 + i, i == 0);
    drain();
    req = "R9";  setup(1, 0, 0, 0, 1);
    for (int i = 0; i < 8; i++) send(4095, 4040 + i, 4095, 1'b0);
    drain();
    req = "R11"; setup(1, 0, 1, 1, 1); bp_mode = 1'b1;
    stream(60, 83, 12); drain();
    bp_mode = 1'b0; repeat (2) @(posedge clk); #2;

    req = "R10"; setup(1, 1, 0, 0, 0);
    send(100, 200, 300, 1'b0);
    @(negedge clk); check("R10 not yet valid", int'(out_valid), 0);
    @(negedge clk); check("R10 valid after two cycles", int'(out_valid), 1);
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (%s) actual=hung expected=done", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule